// File: doc/BRIEF.md
# SPI Flash Identity and Status Responder

This block sits on the device side of a single-lane SPI link in SPI mode 0 and makes the chip look like a serial NOR flash to a host that only probes identity and status. After chip-select falls it collects one command byte. It then answers an identification request with a configurable byte sequence, or returns one byte of a 24-bit status word. A small set of single-byte commands changes the write-enable latch or the 4-byte addressing flag. Array storage, erase, program and multi-lane transfers are not part of it.

The SPI pins are brought into the system clock domain through a synchronizer whose depth is a parameter, and all edge detection runs on that clock. Firmware loads a new status word through a write strobe. That value is held in a staging register and becomes visible on the SPI side only when chip-select next rises. Firmware reads the live status word and the addressing flag directly from output ports.

Top module: `spi_flash_id_status`

## Requirements
- R1: Command bits are taken from `spi_mosi` on rising SCK edges, MSB first. `spi_miso` changes only after a falling SCK edge while selected, and each reply byte is sent MSB first.
- R2: Command 0x9F returns `id_cont_count` bytes of 0x7F. These are followed by `id_mfr`, then `id_dev[7:0]`, then `id_dev[15:8]`.
- R3: After the last identification byte, the reply is 0x00 for as long as SCK keeps toggling.
- R4: Commands 0x05, 0x35 and 0x15 return status bits 7:0, 15:8 and 23:16 respectively. The same byte repeats for as long as SCK keeps toggling.
- R5: Command 0x06 sets status bit 1 (write-enable latch) and command 0x04 clears it. The change lands at the chip-select rising edge that ends the command. It is seen both on `status_live` and in later status reads.
- R6: Command 0xB7 sets `addr_4b` and command 0xE9 clears it, at the end of the transaction. `addr_4b` changes at no other time.
- R7: A word written with `fw_status_we` does not change `status_live` or SPI status reads until the next chip-select rising edge. Any complete transaction, including a lone 0x00 byte, applies it.
- R8: When a staged firmware word and a 0x06 or 0x04 command meet at the same chip-select rising edge, the firmware word is applied first and the write-enable latch change is applied on top of it.
- R9: `spi_miso` is 0 while deselected and during the command byte.
- R10: Any other command returns 0x00 bytes and leaves the status word and `addr_4b` unchanged.
- R11: After reset, `status_live` equals the `RESET_STATUS` parameter (0 by default), `addr_4b` is 0 and `spi_miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| fw_status_we | input | 1 | Firmware strobe that stages a new status word |
| fw_status_wdata | input | 24 | Status word to stage |
| id_cont_count | input | CONT_W | Number of 0x7F continuation bytes in the identification reply |
| id_mfr | input | 8 | Manufacturer byte of the identification reply |
| id_dev | input | 16 | Device code, sent low byte first |
| status_live | output | 24 | Status word currently served on SPI |
| addr_4b | output | 1 | 4-byte addressing flag |

## Verification
The hardest case to reach is the one in R8, where a staged firmware word and a write-enable command take effect at the same chip-select rise. The stimulus stages a word and then runs a single 0x06 transaction, so both updates resolve at one edge. A later status read shows the combined value. A second hard case is the window in R7 between the firmware write and the next rising edge. The bench checks `status_live` against its model on every clock while chip-select is high and an update is pending, and it performs a status read inside that window before the value has latched.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

   localparam int STAT_W  = 24;
   localparam int WEL_BIT = 1;

   localparam logic [7:0] OPC_READ_ID = 8'h9F;
   localparam logic [7:0] OPC_STAT_LO = 8'h05;
   localparam logic [7:0] OPC_STAT_MD = 8'h35;
   localparam logic [7:0] OPC_STAT_HI = 8'h15;
   localparam logic [7:0] OPC_WR_EN   = 8'h06;
   localparam logic [7:0] OPC_WR_DIS  = 8'h04;
   localparam logic [7:0] OPC_A4B_ON  = 8'hB7;
   localparam logic [7:0] OPC_A4B_OFF = 8'hE9;

   typedef enum logic [1:0] {
      PH_OPCODE,
      PH_ID,
      PH_STATUS,
      PH_QUIET
   } phase_e;

   typedef enum logic [2:0] {
      EFF_NONE,
      EFF_WEL_SET,
      EFF_WEL_CLR,
      EFF_A4B_SET,
      EFF_A4B_CLR
   } effect_e;

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
   parameter int SYNC_STAGES = 2,
   parameter bit SYNC_BYPASS = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic csn_i,
   input  logic mosi_i,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_active,
   output logic cs_end,
   output logic mosi_s
);

   // bus layout: {mosi, csn, sck}
   localparam logic [2:0] BUS_RST = 3'b010;

   logic [2:0] raw_i;
   logic [2:0] raw_s;
   logic       sck_q;
   logic       csn_q;

   assign raw_i = {mosi_i, csn_i, sck_i};

   generate
      if (SYNC_BYPASS) begin : g_direct
         assign raw_s = raw_i;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0][2:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < SYNC_STAGES; k++) stage_q[k] <= BUS_RST;
            end else begin
               stage_q[0] <= raw_i;
               for (int k = 1; k < SYNC_STAGES; k++) stage_q[k] <= stage_q[k-1];
            end
         end
         assign raw_s = stage_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         csn_q <= 1'b1;
      end else begin
         sck_q <= raw_s[0];
         csn_q <= raw_s[1];
      end
   end

   assign sck_rise  = raw_s[0] & ~sck_q;
   assign sck_fall  = ~raw_s[0] & sck_q;
   assign cs_active = ~raw_s[1];
   assign cs_end    = raw_s[1] & ~csn_q;
   assign mosi_s    = raw_s[2];

endmodule

// File: rtl/sfr_reply.sv
module sfr_reply
   import sfr_pkg::*;
#(
   parameter int CONT_W = 4,
   parameter int IDX_W  = CONT_W + 2
) (
   input  phase_e              phase,
   input  logic [1:0]          stat_sel,
   input  logic [IDX_W-1:0]    idx,
   input  logic [CONT_W-1:0]   cont,
   input  logic [7:0]          mfr,
   input  logic [15:0]         dev,
   input  logic [STAT_W-1:0]   status,
   output logic [7:0]          byte_o
);

   logic [IDX_W-1:0] cont_x;
   logic [IDX_W-1:0] dev_lo_idx;
   logic [IDX_W-1:0] dev_hi_idx;

   assign cont_x     = {{(IDX_W-CONT_W){1'b0}}, cont};
   assign dev_lo_idx = cont_x + IDX_W'(1);
   assign dev_hi_idx = cont_x + IDX_W'(2);

   always_comb begin
      byte_o = 8'h00;
      case (phase)
         PH_ID: begin
            if (idx < cont_x)           byte_o = 8'h7F;
            else if (idx == cont_x)     byte_o = mfr;
            else if (idx == dev_lo_idx) byte_o = dev[7:0];
            else if (idx == dev_hi_idx) byte_o = dev[15:8];
         end
         PH_STATUS: begin
            case (stat_sel)
               2'd0:    byte_o = status[7:0];
               2'd1:    byte_o = status[15:8];
               2'd2:    byte_o = status[23:16];
               default: byte_o = 8'h00;
            endcase
         end
         default: byte_o = 8'h00;
      endcase
   end

endmodule

// File: rtl/sfr_decoder.sv
module sfr_decoder
   import sfr_pkg::*;
#(
   parameter int CONT_W = 4,
   parameter int IDX_W  = CONT_W + 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sck_rise,
   input  logic                sck_fall,
   input  logic                cs_active,
   input  logic                mosi_s,
   input  logic [7:0]          reply_byte,
   output phase_e              phase,
   output logic [1:0]          stat_sel,
   output logic [IDX_W-1:0]    idx,
   output effect_e             effect,
   output logic                miso
);

   localparam logic [IDX_W-1:0] IDX_MAX = '1;

   logic [2:0] bit_cnt;
   logic [6:0] rx_sh;
   logic [7:0] tx_sh;
   logic [7:0] opc_full;

   assign opc_full = {rx_sh, mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_OPCODE;
         stat_sel <= 2'd0;
         idx      <= '0;
         effect   <= EFF_NONE;
         bit_cnt  <= 3'd0;
         rx_sh    <= 7'd0;
         tx_sh    <= 8'd0;
      end else if (!cs_active) begin
         phase    <= PH_OPCODE;
         idx      <= '0;
         effect   <= EFF_NONE;
         bit_cnt  <= 3'd0;
         rx_sh    <= 7'd0;
         tx_sh    <= 8'd0;
      end else begin
         if (sck_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            rx_sh   <= {rx_sh[5:0], mosi_s};
            if (phase == PH_OPCODE && bit_cnt == 3'd7) begin
               phase <= PH_QUIET;
               case (opc_full)
                  OPC_READ_ID: phase <= PH_ID;
                  OPC_STAT_LO: begin phase <= PH_STATUS; stat_sel <= 2'd0; end
                  OPC_STAT_MD: begin phase <= PH_STATUS; stat_sel <= 2'd1; end
                  OPC_STAT_HI: begin phase <= PH_STATUS; stat_sel <= 2'd2; end
                  OPC_WR_EN:   effect <= EFF_WEL_SET;
                  OPC_WR_DIS:  effect <= EFF_WEL_CLR;
                  OPC_A4B_ON:  effect <= EFF_A4B_SET;
                  OPC_A4B_OFF: effect <= EFF_A4B_CLR;
                  default:     effect <= EFF_NONE;
               endcase
            end
         end else if (sck_fall) begin
            if (phase != PH_OPCODE && bit_cnt == 3'd0) begin
               tx_sh <= reply_byte;
               if (idx != IDX_MAX) idx <= idx + IDX_W'(1);
            end else begin
               tx_sh <= {tx_sh[6:0], 1'b0};
            end
         end
      end
   end

   assign miso = tx_sh[7];

endmodule

// File: rtl/sfr_status.sv
module sfr_status
   import sfr_pkg::*;
#(
   parameter logic [STAT_W-1:0] RESET_STATUS = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fw_we,
   input  logic [STAT_W-1:0] fw_wdata,
   input  logic              cs_end,
   input  effect_e           effect,
   output logic [STAT_W-1:0] live,
   output logic              a4b
);

   logic [STAT_W-1:0] staged;
   logic              pend;
   logic [STAT_W-1:0] next_live;

   always_comb begin
      next_live = pend ? staged : live;
      case (effect)
         EFF_WEL_SET: next_live[WEL_BIT] = 1'b1;
         EFF_WEL_CLR: next_live[WEL_BIT] = 1'b0;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live   <= RESET_STATUS;
         a4b    <= 1'b0;
         staged <= '0;
         pend   <= 1'b0;
      end else begin
         if (fw_we) staged <= fw_wdata;
         if (cs_end) begin
            live <= next_live;
            pend <= fw_we;
            if (effect == EFF_A4B_SET) a4b <= 1'b1;
            if (effect == EFF_A4B_CLR) a4b <= 1'b0;
         end else if (fw_we) begin
            pend <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/spi_flash_id_status.sv
module spi_flash_id_status
   import sfr_pkg::*;
#(
   parameter int                CONT_W       = 4,
   parameter int                SYNC_STAGES  = 2,
   parameter bit                SYNC_BYPASS  = 1'b0,
   parameter logic [STAT_W-1:0] RESET_STATUS = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_csn,
   input  logic              spi_mosi,
   output logic              spi_miso,
   input  logic              fw_status_we,
   input  logic [STAT_W-1:0] fw_status_wdata,
   input  logic [CONT_W-1:0] id_cont_count,
   input  logic [7:0]        id_mfr,
   input  logic [15:0]       id_dev,
   output logic [STAT_W-1:0] status_live,
   output logic              addr_4b
);

   localparam int IDX_W = CONT_W + 2;

   generate
      if (CONT_W < 1 || CONT_W > 8) begin : g_bad_cont
         $error("CONT_W must lie in 1..8");
      end
      if (!SYNC_BYPASS && SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2 when synchronizing");
      end
   endgenerate

   logic             sck_rise;
   logic             sck_fall;
   logic             cs_active;
   logic             cs_end;
   logic             mosi_s;
   phase_e           phase;
   logic [1:0]       stat_sel;
   logic [IDX_W-1:0] idx;
   effect_e          effect;
   logic [7:0]       reply_byte;

   sfr_sync #(
      .SYNC_STAGES (SYNC_STAGES),
      .SYNC_BYPASS (SYNC_BYPASS)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_i     (spi_sck),
      .csn_i     (spi_csn),
      .mosi_i    (spi_mosi),
      .sck_rise  (sck_rise),
      .sck_fall  (sck_fall),
      .cs_active (cs_active),
      .cs_end    (cs_end),
      .mosi_s    (mosi_s)
   );

   sfr_decoder #(
      .CONT_W (CONT_W),
      .IDX_W  (IDX_W)
   ) u_decoder (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck_rise   (sck_rise),
      .sck_fall   (sck_fall),
      .cs_active  (cs_active),
      .mosi_s     (mosi_s),
      .reply_byte (reply_byte),
      .phase      (phase),
      .stat_sel   (stat_sel),
      .idx        (idx),
      .effect     (effect),
      .miso       (spi_miso)
   );

   sfr_reply #(
      .CONT_W (CONT_W),
      .IDX_W  (IDX_W)
   ) u_reply (
      .phase    (phase),
      .stat_sel (stat_sel),
      .idx      (idx),
      .cont     (id_cont_count),
      .mfr      (id_mfr),
      .dev      (id_dev),
      .status   (status_live),
      .byte_o   (reply_byte)
   );

   sfr_status #(
      .RESET_STATUS (RESET_STATUS)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .fw_we    (fw_status_we),
      .fw_wdata (fw_status_wdata),
      .cs_end   (cs_end),
      .effect   (effect),
      .live     (status_live),
      .a4b      (addr_4b)
   );

endmodule

// File: rtl/sfr_chk.sv
module sfr_chk
   import sfr_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              cs_active,
   input logic              cs_end,
   input logic              sck_fall,
   input effect_e           effect,
   input logic              spi_miso,
   input logic [STAT_W-1:0] status_live,
   input logic              addr_4b
);

   AST_MISO_QUIET_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_active |=> !spi_miso); // R9

   AST_MISO_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_active && !sck_fall) |=> $stable(spi_miso)); // R1

   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_end |=> $stable(status_live)); // R7

   AST_A4B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_end |=> $stable(addr_4b)); // R6

   AST_WEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_end && effect == EFF_WEL_SET) |=> status_live[WEL_BIT]); // R5

   AST_WEL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_end && effect == EFF_WEL_CLR) |=> !status_live[WEL_BIT]); // R5

   AST_A4B_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_end && effect == EFF_A4B_SET) |=> addr_4b); // R6

   AST_A4B_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_end && effect == EFF_A4B_CLR) |=> !addr_4b); // R6

endmodule

bind spi_flash_id_status sfr_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs_active   (cs_active),
   .cs_end      (cs_end),
   .sck_fall    (sck_fall),
   .effect      (effect),
   .spi_miso    (spi_miso),
   .status_live (status_live),
   .addr_4b     (addr_4b)
);

// File: tb/spi_flash_id_status_bench.sv
module spi_flash_id_status_bench;

   localparam int CW   = 4;
   localparam int HALF = 6;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n;
   logic          sck;
   logic          csn;
   logic          mosi;
   logic          fw_we;
   logic [23:0]   fw_wd;
   logic [CW-1:0] cont;
   logic [7:0]    mfr;
   logic [15:0]   dev;
   wire           miso;
   wire  [23:0]   st;
   wire           a4b;

   int   n_cmp = 0;
   int   n_bad = 0;
   bit   settled = 1'b0;
   bit   done = 1'b0;

   logic [23:0] m_status;
   logic [23:0] m_staged;
   bit          m_pend;
   bit          m_a4b;

   spi_flash_id_status #(.CONT_W(CW)) u_spi_flash_id_status (
      .clk             (clk),
      .rst_n           (rst_n),
      .spi_sck         (sck),
      .spi_csn         (csn),
      .spi_mosi        (mosi),
      .spi_miso        (miso),
      .fw_status_we    (fw_we),
      .fw_status_wdata (fw_wd),
      .id_cont_count   (cont),
      .id_mfr          (mfr),
      .id_dev          (dev),
      .status_live     (st),
      .addr_4b         (a4b)
   );

   // per-clock comparison of firmware-visible state against the model
   always @(negedge clk) begin
      if (rst_n && settled) begin
         n_cmp++;
         if (st !== m_status) begin
            n_bad++;
            $display("FAIL R5/R7 status_live act %h exp %h", st, m_status);
         end
         n_cmp++;
         if (a4b !== m_a4b) begin
            n_bad++;
            $display("FAIL R6 addr_4b act %0b exp %0b", a4b, m_a4b);
         end
         if (csn) begin
            n_cmp++;
            if (miso !== 1'b0) begin
               n_bad++;
               $display("FAIL R9 miso idle act %0b exp 0", miso);
            end
         end
      end
   end

   function automatic logic [7:0] model_byte(input logic [7:0] opc, input int k);
      int c;
      c = int'(cont);
      case (opc)
         8'h9F: begin
            if (k < c)           return 8'h7F;
            else if (k == c)     return mfr;
            else if (k == c + 1) return dev[7:0];
            else if (k == c + 2) return dev[15:8];
            else                 return 8'h00;
         end
         8'h05: return m_status[7:0];
         8'h35: return m_status[15:8];
         8'h15: return m_status[23:16];
         default: return 8'h00;
      endcase
   endfunction

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_bit(input string tag, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s miso bit act %0b exp %0b", tag, act, exp);
      end
   endtask

   task automatic fw_write(input logic [23:0] v);
      fw_we = 1'b1;
      fw_wd = v;
      step(1);
      fw_we    = 1'b0;
      m_staged = v;
      m_pend   = 1'b1;
   endtask

   task automatic txn(input logic [7:0] opc, input int nrx, input string tag);
      logic [23:0] base;
      csn = 1'b0;
      step(HALF);
      for (int b = 0; b <= nrx; b++) begin
         logic [7:0] out_b;
         logic [7:0] exp_b;
         out_b = (b == 0) ? opc : 8'h00;
         exp_b = (b == 0) ? 8'h00 : model_byte(opc, b - 1);
         for (int i = 7; i >= 0; i--) begin
            sck  = 1'b0;
            mosi = out_b[i];
            step(HALF);
            check_bit((b == 0) ? "R9" : tag, miso, exp_b[i]);
            sck = 1'b1;
            step(HALF);
         end
      end
      sck  = 1'b0;
      mosi = 1'b0;
      step(HALF);
      csn     = 1'b1;
      settled = 1'b0;
      step(8);
      base = m_pend ? m_staged : m_status;
      if (opc == 8'h06) base[1] = 1'b1;
      if (opc == 8'h04) base[1] = 1'b0;
      m_status = base;
      m_pend   = 1'b0;
      if (opc == 8'hB7) m_a4b = 1'b1;
      if (opc == 8'hE9) m_a4b = 1'b0;
      settled = 1'b1;
      step(2);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      rst_n = 1'b0; sck = 1'b0; csn = 1'b1; mosi = 1'b0;
      fw_we = 1'b0; fw_wd = '0;
      cont = 4'd3; mfr = 8'h56; dev = 16'h1234;
      m_status = 24'h0; m_staged = 24'h0; m_pend = 1'b0; m_a4b = 1'b0;
      step(5);
      rst_n = 1'b1;
      step(2);
      // R11: reset state
      n_cmp++;
      if (st !== 24'h0 || a4b !== 1'b0 || miso !== 1'b0) begin
         n_bad++;
         $display("FAIL R11 reset act %h/%0b/%0b exp 000000/0/0", st, a4b, miso);
      end
      settled = 1'b1;

      // R2, R3: identification with three continuation bytes, zeros afterwards
      txn(8'h9F, 10, "R2/R3");
      // R2: no continuation bytes, other codes
      cont = 4'd0; mfr = 8'hA5; dev = 16'hC33C;
      txn(8'h9F, 6, "R2/R3");
      // R2: maximum continuation count
      cont = 4'd15; mfr = 8'h81; dev = 16'h7E01;
      txn(8'h9F, 20, "R2/R3");

      // R4: reset status repeats
      txn(8'h05, 3, "R4");

      // R7: staged value not visible before a chip-select rise
      fw_write(24'h5A55AA);
      step(20);
      txn(8'h05, 1, "R7");
      // R4: each status byte, repeated
      txn(8'h05, 2, "R4");
      txn(8'h35, 2, "R4");
      txn(8'h15, 3, "R4");

      // R5: write-disable then write-enable
      txn(8'h04, 0, "R5");
      txn(8'h05, 1, "R5");
      txn(8'h06, 0, "R5");
      txn(8'h05, 1, "R5");

      // R6: addressing flag
      txn(8'hB7, 0, "R6");
      txn(8'h05, 1, "R6");
      txn(8'hE9, 0, "R6");

      // R8: staged word and write-enable meet at one edge
      fw_write(24'h000001);
      txn(8'h06, 0, "R8");
      txn(8'h05, 1, "R8");
      fw_write(24'hFFFFFF);
      txn(8'h04, 0, "R8");
      txn(8'h15, 1, "R8");
      txn(8'h05, 1, "R8");

      // R10: unknown command returns zeros and changes nothing
      txn(8'hAB, 3, "R10");
      txn(8'h05, 1, "R10");

      // R7: a lone zero command latches a staged word
      fw_write(24'h123456);
      step(30);
      txn(8'h00, 0, "R7");
      txn(8'h35, 1, "R7");

      // R1: a transaction whose bits alternate exercises the bit order
      cont = 4'd1; mfr = 8'hA5; dev = 16'h5A0F;
      txn(8'h9F, 5, "R1");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule